// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Controller

This controller carries out the register and stack work of taking and leaving an interrupt on a 16-bit processor with a code segment register. A software request brings an 8-bit vector number. An external key event always uses vector 0. For either one, the unit first checks the interrupt-enable flag. It then reads a length-prefixed vector table from memory, saves the current code segment and instruction pointer on a stack that grows toward higher addresses, and hands back the new register values: code segment 0 and the handler address as instruction pointer. A return request restores the instruction pointer first and the code segment second, both from the stack.

The core's register file supplies the current CS, IP and SP. When a sequence completes, the unit presents the new values for one cycle, marked by `done`. All memory traffic goes through a single 16-bit word port with a valid/ready handshake. A bad entry (interrupts disabled, or a vector beyond the table) raises an error pulse and a halt pulse and writes nothing. External key events are throttled by a cooldown counter that counts executed instructions. The instruction decoder reports each executed instruction and each halt instruction to the unit.

Top module: `irq_vector_unit`

## Requirements
- R1: A `tbl_load` pulse stores `tbl_base` as the table base. The word at the base is the entry count. The handler for vector n is the word at base + 2 + 2*n.
- R2: A software request while `ie_flag` is 0 makes `err_set` and `halt_req` high for exactly one cycle. No memory access is made and `done` is not raised.
- R3: A software request whose vector is greater than or equal to the entry count makes `err_set` and `halt_req` high for one cycle. No stack write is made and `done` is not raised.
- R4: A successful entry writes CS to SP+2 and then IP to SP+4. It then raises `done` for one cycle with `cs_out`=0, `ip_out`=handler and `sp_out`=SP+4.
- R5: A return reads IP from address SP and CS from address SP-2. It then raises `done` for one cycle with those values and `sp_out`=SP-4.
- R6: An accepted key event runs an entry with vector 0. On completion `key_port` holds the key code captured when the event was accepted.
- R7: The cooldown counter starts at 10 after reset and is reloaded to 10 when a key event is accepted. Each `insn_step` pulse lowers it by 1, stopping at 0. A `halt_insn` pulse sets it to 0.
- R8: A key event is dropped and never queued if the cooldown is non-zero, if `ie_flag` is 0, or if the unit is busy. `key_port` then keeps its old value.
- R9: While `mem_valid` is high and `mem_ready` is low, the request (address, write enable, write data) holds steady. Read data is taken in the cycle where valid and ready are both high.
- R10: When idle, a software request wins over a return request, and a return request wins over a key event. A key event that loses to another request is dropped, and the cooldown is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_load | input | 1 | Load the vector table base |
| tbl_base | input | 16 | New table base address |
| sw_req | input | 1 | Software interrupt request |
| sw_id | input | 8 | Software interrupt vector number |
| ret_req | input | 1 | Return-from-interrupt request |
| key_evt | input | 1 | External key event |
| key_code | input | 16 | Key code carried by the event |
| insn_step | input | 1 | One instruction was executed |
| halt_insn | input | 1 | A halt instruction was executed |
| ie_flag | input | 1 | Interrupt-enable flag from the flags register |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with ready |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse; register outputs valid |
| cs_out | output | 16 | New code segment |
| ip_out | output | 16 | New instruction pointer |
| sp_out | output | 16 | New stack pointer |
| err_set | output | 1 | Set the error flag (one-cycle pulse) |
| halt_req | output | 1 | Stop execution (one-cycle pulse) |
| key_port | output | 16 | Input port 0: last accepted key code |

## Verification
The bench tests vectors at the edge of the table. The vector equal to the entry count must fault without writing the stack; an off-by-one compare would instead fetch a handler from past the end of the table. The cooldown is walked down one instruction at a time, and a key event is offered at a count of 1 and again at 0. A counter that reloads wrong or that queues events would then accept too early or run a late entry. Stalled memory responses check that pushes land at SP+2 and SP+4 in that order, and that a return reads SP before SP-2. Simultaneous software and key requests check that the key event is dropped and does not consume the cooldown.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int W        = 16,
  parameter int IDW      = 8,
  parameter int COOLDOWN = 10,
  parameter int COOL_W   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_load,
  input  logic [W-1:0]  tbl_base,
  input  logic          sw_req,
  input  logic [IDW-1:0] sw_id,
  input  logic          ret_req,
  input  logic          key_evt,
  input  logic [W-1:0]  key_code,
  input  logic          insn_step,
  input  logic          halt_insn,
  input  logic          ie_flag,
  input  logic [W-1:0]  cs_in,
  input  logic [W-1:0]  ip_in,
  input  logic [W-1:0]  sp_in,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  cs_out,
  output logic [W-1:0]  ip_out,
  output logic [W-1:0]  sp_out,
  output logic          err_set,
  output logic          halt_req,
  output logic [W-1:0]  key_port
);
  localparam logic [W-1:0] WSTEP = W'(2);
  localparam logic [COOL_W-1:0] RELOAD = COOL_W'(COOLDOWN);

  typedef enum logic [3:0] {
    S_IDLE, S_LEN, S_VEC, S_PCS, S_PIP, S_RIP, S_RCS, S_DONE, S_FAULT
  } st_t;

  st_t st;
  logic [W-1:0] base_q, hnd_q, cs_q, ip_q, sp_q, kcode_q;
  logic [IDW-1:0] id_q;
  logic kflag_q;
  logic [COOL_W-1:0] cool;

  wire idle    = (st == S_IDLE);
  wire key_acc = idle && key_evt && ie_flag && (cool == '0) && !sw_req && !ret_req;
  wire xfer    = mem_valid && mem_ready;

  assign busy      = !idle;
  assign done      = (st == S_DONE);
  assign err_set   = (st == S_FAULT);
  assign halt_req  = (st == S_FAULT);
  assign mem_valid = st inside {S_LEN, S_VEC, S_PCS, S_PIP, S_RIP, S_RCS};
  assign mem_we    = st inside {S_PCS, S_PIP};

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_LEN: mem_addr = base_q;
      S_VEC: mem_addr = base_q + WSTEP + (W'(id_q) << 1);
      S_PCS: begin mem_addr = sp_q + WSTEP;         mem_wdata = cs_q; end
      S_PIP: begin mem_addr = sp_q + WSTEP + WSTEP; mem_wdata = ip_q; end
      S_RIP: mem_addr = sp_q;
      S_RCS: mem_addr = sp_q - WSTEP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_q   <= '0;
      hnd_q    <= '0;
      cs_q     <= '0;
      ip_q     <= '0;
      sp_q     <= '0;
      kcode_q  <= '0;
      id_q     <= '0;
      kflag_q  <= 1'b0;
      cs_out   <= '0;
      ip_out   <= '0;
      sp_out   <= '0;
      key_port <= '0;
    end else begin
      if (tbl_load) base_q <= tbl_base;
      case (st)
        S_IDLE: begin
          cs_q <= cs_in;
          ip_q <= ip_in;
          sp_q <= sp_in;
          if (sw_req) begin
            id_q    <= sw_id;
            kflag_q <= 1'b0;
            st      <= ie_flag ? S_LEN : S_FAULT;
          end else if (ret_req) begin
            st <= S_RIP;
          end else if (key_acc) begin
            id_q    <= '0;
            kflag_q <= 1'b1;
            kcode_q <= key_code;
            st      <= S_LEN;
          end
        end
        S_LEN: if (xfer) st <= (W'(id_q) >= mem_rdata) ? S_FAULT : S_VEC;
        S_VEC: if (xfer) begin hnd_q <= mem_rdata; st <= S_PCS; end
        S_PCS: if (xfer) st <= S_PIP;
        S_PIP: if (xfer) begin
          cs_out <= '0;
          ip_out <= hnd_q;
          sp_out <= sp_q + WSTEP + WSTEP;
          if (kflag_q) key_port <= kcode_q;
          st <= S_DONE;
        end
        S_RIP: if (xfer) begin ip_out <= mem_rdata; st <= S_RCS; end
        S_RCS: if (xfer) begin
          cs_out <= mem_rdata;
          sp_out <= sp_q - WSTEP - WSTEP;
          st     <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          cool <= RELOAD;
    else if (key_acc)                    cool <= RELOAD;
    else if (halt_insn)                  cool <= '0;
    else if (insn_step && cool != '0)    cool <= cool - 1'b1;
  end
endmodule

module irq_vector_unit_chk #(
  parameter int W      = 16,
  parameter int COOL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [W-1:0]      mem_addr,
  input logic [W-1:0]      mem_wdata,
  input logic              done,
  input logic              err_set,
  input logic              busy,
  input logic              key_evt,
  input logic              sw_req,
  input logic              ret_req,
  input logic              insn_step,
  input logic              halt_insn,
  input logic              key_acc,
  input logic [COOL_W-1:0] cool
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> !err_set && !busy);

  assert_cool_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    insn_step && !halt_insn && !key_acc && cool != '0 |=> cool == $past(cool) - 1'b1);

  assert_halt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_insn && !key_acc |=> cool == '0);

  assert_key_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && key_evt && cool != '0 && !sw_req && !ret_req |=> !busy);
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.W(16), .COOL_W(8)) chk_i (.*);

// File: tb/irq_vector_unit_tb.sv
`timescale 1ns/1ps
module irq_vector_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_load = 0, sw_req = 0, ret_req = 0, key_evt = 0, insn_step = 0, halt_insn = 0, ie_flag = 0;
  logic [15:0] tbl_base = 0, key_code = 0, cs_in = 0, ip_in = 0, sp_in = 0;
  logic [7:0] sw_id = 0;
  logic mem_valid, mem_ready, mem_we, busy, done, err_set, halt_req;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, cs_out, ip_out, sp_out, key_port;

  int n_cmp = 0, n_bad = 0;
  int n_wr = 0, n_acc = 0, cyc = 0;
  bit stall = 0;
  logic [15:0] mem_q [0:127];

  always #2 clk = ~clk;

  irq_vector_unit dut_i (.*);

  assign mem_ready = stall ? cyc[0] : 1'b1;
  assign mem_rdata = mem_q[mem_addr[7:1]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && mem_ready) begin
      n_acc <= n_acc + 1;
      if (mem_we) begin
        mem_q[mem_addr[7:1]] <= mem_wdata;
        n_wr <= n_wr + 1;
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic set_table(logic [15:0] b, logic [15:0] len);
    mem_q[b[7:1]] = len;
    for (int i = 0; i < 4; i++) mem_q[b[7:1] + 1 + i] = 16'h1000 * (i + 1) + b;
    @(negedge clk); tbl_base = b; tbl_load = 1;
    @(negedge clk); tbl_load = 0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_err);
    got_done = 0; got_err = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin got_done = 1; break; end
      if (err_set) begin got_err = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R7 reset busy", {15'd0, busy}, 16'd0);
    chk("R2 reset err", {15'd0, err_set}, 16'd0);
    chk("R6 reset key_port", key_port, 16'd0);
  endtask

  task automatic t_entry(logic [7:0] id, logic [15:0] sp, bit stl, string tag);
    bit d, e;
    stall = stl; ie_flag = 1;
    sp_in = sp; cs_in = 16'h0C00 + 16'(id); ip_in = 16'h0200 + sp;
    @(negedge clk); sw_id = id; sw_req = 1;
    @(negedge clk); sw_req = 0;
    wait_end(d, e);
    chk({tag, " done"}, {15'd0, d}, 16'd1);
    chk({tag, " cs_out"}, cs_out, 16'd0);
    chk({tag, " ip_out"}, ip_out, 16'h1000 * (16'(id) + 1) + tbl_base);
    chk({tag, " sp_out"}, sp_out, sp + 4);
    chk({tag, " stack cs"}, mem_q[(sp + 2) >> 1], 16'h0C00 + 16'(id));
    chk({tag, " stack ip"}, mem_q[(sp + 4) >> 1], 16'h0200 + sp);
    @(negedge clk);
    chk({tag, " done one cycle"}, {15'd0, done}, 16'd0);
    stall = 0;
  endtask

  task automatic t_range;
    bit d, e; int w0;
    ie_flag = 1; w0 = n_wr;
    @(negedge clk); sw_id = 8'd3; sw_req = 1;
    @(negedge clk); sw_req = 0;
    wait_end(d, e);
    chk("R3 err at id==len", {15'd0, e}, 16'd1);
    chk("R3 halt at id==len", {15'd0, halt_req}, 16'd1);
    chk("R3 no stack write", 16'(n_wr - w0), 16'd0);
    @(negedge clk);
    chk("R3 err one cycle", {15'd0, err_set}, 16'd0);
  endtask

  task automatic t_ie_off;
    bit d, e; int a0;
    ie_flag = 0; a0 = n_acc;
    @(negedge clk); sw_id = 8'd0; sw_req = 1;
    @(negedge clk); sw_req = 0;
    wait_end(d, e);
    chk("R2 err when disabled", {15'd0, e}, 16'd1);
    chk("R2 halt when disabled", {15'd0, halt_req}, 16'd1);
    chk("R2 no done", {15'd0, d}, 16'd0);
    chk("R2 no memory access", 16'(n_acc - a0), 16'd0);
    @(negedge clk);
    chk("R2 err one cycle", {15'd0, err_set}, 16'd0);
    ie_flag = 1;
  endtask

  task automatic t_return(bit stl);
    bit d, e;
    stall = stl;
    mem_q[16'h0030 >> 1] = 16'hA5A4;
    mem_q[16'h002E >> 1] = 16'h0007;
    sp_in = 16'h0030;
    pulse(ret_req);
    wait_end(d, e);
    chk("R5 done", {15'd0, d}, 16'd1);
    chk("R5 ip from [SP]", ip_out, 16'hA5A4);
    chk("R5 cs from [SP-2]", cs_out, 16'h0007);
    chk("R5 sp_out", sp_out, 16'h002C);
    stall = 0;
  endtask

  task automatic key_try(logic [15:0] code, output bit taken);
    @(negedge clk); key_code = code; key_evt = 1;
    @(negedge clk); key_evt = 0;
    taken = busy;
  endtask

  task automatic t_cooldown;
    bit tk, d, e;
    ie_flag = 1; sp_in = 16'h0050; cs_in = 16'h0003; ip_in = 16'h0123;
    key_try(16'h1111, tk);
    chk("R8 key dropped during reset cooldown", {15'd0, tk}, 16'd0);
    repeat (9) pulse(insn_step);
    key_try(16'h2222, tk);
    chk("R7 key dropped at cooldown 1", {15'd0, tk}, 16'd0);
    pulse(insn_step);
    key_try(16'hBEEF, tk);
    chk("R7 key taken at cooldown 0", {15'd0, tk}, 16'd1);
    wait_end(d, e);
    chk("R6 key entry done", {15'd0, d}, 16'd1);
    chk("R6 vector 0 handler", ip_out, 16'h1000 + tbl_base);
    chk("R6 key_port", key_port, 16'hBEEF);
    chk("R6 stack ip", mem_q[16'h0054 >> 1], 16'h0123);
    @(negedge clk);
    key_try(16'h3333, tk);
    chk("R7 reloaded after accept", {15'd0, tk}, 16'd0);
    chk("R8 key_port kept", key_port, 16'hBEEF);
  endtask

  task automatic t_halt_and_drop;
    bit tk, d, e;
    ie_flag = 0; pulse(halt_insn);
    key_try(16'h4444, tk);
    chk("R8 key dropped ie off", {15'd0, tk}, 16'd0);
    ie_flag = 1;
    key_try(16'h5555, tk);
    chk("R7 halt cleared cooldown", {15'd0, tk}, 16'd1);
    wait_end(d, e);
    chk("R6 key_port after halt", key_port, 16'h5555);
    pulse(halt_insn);
    stall = 1; sp_in = 16'h0060;
    @(negedge clk); sw_id = 8'd2; sw_req = 1;
    @(negedge clk); sw_req = 0;
    @(negedge clk); key_code = 16'h6666; key_evt = 1;
    @(negedge clk); key_evt = 0;
    wait_end(d, e);
    chk("R8 busy entry done", ip_out, 16'h3000 + tbl_base);
    repeat (3) @(negedge clk);
    chk("R8 key while busy not queued", {15'd0, busy}, 16'd0);
    chk("R8 key_port unchanged", key_port, 16'h5555);
    stall = 0;
  endtask

  task automatic t_priority;
    bit tk, d, e;
    pulse(halt_insn);
    @(negedge clk); sw_id = 8'd1; sw_req = 1; key_code = 16'h7777; key_evt = 1;
    @(negedge clk); sw_req = 0; key_evt = 0;
    wait_end(d, e);
    chk("R10 sw wins over key", ip_out, 16'h2000 + tbl_base);
    chk("R10 key_port unchanged", key_port, 16'h5555);
    @(negedge clk);
    key_try(16'h8888, tk);
    chk("R10 cooldown not consumed", {15'd0, tk}, 16'd1);
    wait_end(d, e);
    chk("R10 later key port", key_port, 16'h8888);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem_q[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    set_table(16'h0040, 16'd3);
    t_entry(8'd0, 16'h0010, 0, "R4 id0");
    t_entry(8'd2, 16'h0020, 1, "R9 stalled id2");
    t_range;
    t_ie_off;
    t_return(0);
    t_return(1);
    set_table(16'h0080, 16'd2);
    t_entry(8'd1, 16'h0010, 0, "R1 new base id1");
    set_table(16'h0040, 16'd3);
    t_cooldown;
    t_halt_and_drop;
    t_priority;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule